// File: doc/BRIEF.md
# Alternate-Byte Register Transfer Sequencer

This block carries out one peripheral-style transfer between a 32-bit data register and memory bytes at every second address. An 8-bit device wired to a single lane of a 16-bit bus sees its registers at alternate byte addresses. The block lets a whole register be spread over, or gathered from, such a device in one operation.

The caller presents a 16-bit opcode word and a 16-bit displacement word with a one-cycle `start`. The block checks the opcode, then reads the selected address and data registers through a combinational register-file read port. It computes the first byte address and issues two or four single-byte bus accesses, most significant byte first. The address steps by two between accesses. Loads end with one register write-back cycle. Every operation ends with a one-cycle `done`.

Top module: `altbyte_xfer`

## Requirements
- R1: An opcode is accepted only when `(opcode & 16'hF138) == 16'h0108`. Any other opcode presented with `start` causes a one-cycle `unsupported` pulse in the following cycle, with no bus access and `busy` kept low.
- R2: Opcode bits 11:9 give the data-register index (`rf_dsel`, and `rf_widx` on write-back). Opcode bits 2:0 give the address-register index (`rf_asel`).
- R3: The first access address equals the address register plus the sign-extended displacement, modulo 2^32.
- R4: Opcode bit 6 set moves four bytes. Opcode bit 6 clear moves two bytes.
- R5: Opcode bit 7 set stores register bytes to memory (`mem_we`=1). Opcode bit 7 clear loads from memory (`mem_we`=0).
- R6: Bytes are ordered most significant first. A four-byte store drives register bits 31:24 at the first address. A two-byte store drives bits 15:8 at the first address.
- R7: Each access after the first uses an address 2 higher than the previous one, with 32-bit wrap-around.
- R8: While `mem_req` is high and `mem_ack` has not been sampled, `mem_addr`, `mem_we` and `mem_wdata` stay constant.
- R9: A load raises `rf_we` for exactly one cycle, in the cycle after the final acknowledge, with `rf_widx` equal to the data-register index. A four-byte load writes the four bytes read, in address order from MSB down. A two-byte load writes the old bits 31:16 unchanged above the two bytes read. A store never raises `rf_we`, so the address register is never written.
- R10: `done` is high for exactly one cycle. For a store it comes in the cycle after the final acknowledge. For a load it comes in the cycle after `rf_we`.
- R11: A `start` while `busy` is high is ignored. The running operation completes unchanged and no further operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (idle only) |
| opcode | input | 16 | Instruction opcode word |
| disp | input | 16 | Signed displacement word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| unsupported | output | 1 | One-cycle pulse for a rejected opcode |
| rf_dsel | output | 3 | Data-register read index |
| rf_asel | output | 3 | Address-register read index |
| rf_dval | input | 32 | Data-register read value |
| rf_aval | input | 32 | Address-register read value |
| rf_we | output | 1 | Data-register write strobe |
| rf_widx | output | 3 | Data-register write index |
| rf_wdata | output | 32 | Data-register write value |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with ack |
| mem_ack | input | 1 | Access acknowledge |

## Verification
Every pairing of the eight data and eight address registers is swept across all four size/direction combinations. Displacements include zero, the most negative value, -1 and a wrap past 2^32, so a wrong sign extension or a wrong stride shows up as an address error. Memory returns bytes that are a function of the address, and register contents are distinct per byte. This separates byte-order errors from lane-merge errors and shows whether a word load disturbs the upper half. Acknowledge latency varies from zero to three cycles per byte, which exercises request hold and the back-to-back case. A subset repeats `start` mid-operation. All eight single-bit corruptions of the recognised pattern, plus a spread of scattered opcodes, confirm rejection.

// File: rtl/altbyte_pkg.sv
package altbyte_pkg;
  localparam logic [15:0] OPC_MASK  = 16'hF138;
  localparam logic [15:0] OPC_MATCH = 16'h0108;
  localparam int          IDX_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MOVE,
    ST_WB,
    ST_FIN
  } seq_state_t;

  typedef struct packed {
    logic [IDX_W-1:0] dsel;
    logic [IDX_W-1:0] asel;
    logic             is_long;
    logic             to_mem;
  } op_fields_t;
endpackage

// File: rtl/altbyte_decode.sv
module altbyte_decode
  import altbyte_pkg::*;
(
  input  logic [15:0] op_i,
  output logic        hit_o,
  output op_fields_t  fld_o
);
  always_comb begin
    hit_o         = (op_i & OPC_MASK) == OPC_MATCH;
    fld_o.dsel    = op_i[11:9];
    fld_o.asel    = op_i[2:0];
    fld_o.is_long = op_i[6];
    fld_o.to_mem  = op_i[7];
  end
endmodule

// File: rtl/altbyte_step.sv
module altbyte_step #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int CNT_W  = 2,
  parameter int STRIDE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [CNT_W-1:0]  cnt_init_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              last_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  always_comb begin
    addr_n = addr_q;
    cnt_n  = cnt_q;
    if (load_en) begin
      addr_n = base_i + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
      cnt_n  = cnt_init_i;
    end else if (step_en) begin
      addr_n = addr_q + ADDR_W'(STRIDE);
      cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_en || step_en) begin
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/altbyte_lane.sv
module altbyte_lane #(
  parameter int NBYTES = 4,
  parameter int CNT_W  = 2
) (
  input  logic [8*NBYTES-1:0] word_i,
  input  logic [CNT_W-1:0]    idx_i,
  input  logic [7:0]          byte_i,
  output logic [7:0]          byte_o,
  output logic [8*NBYTES-1:0] word_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign word_o[8*g +: 8] = (idx_i == CNT_W'(g)) ? byte_i : word_i[8*g +: 8];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (idx_i == CNT_W'(k)) byte_o = word_i[8*k +: 8];
    end
  end
endmodule

// File: rtl/altbyte_xfer.sv
module altbyte_xfer
  import altbyte_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 16,
  parameter int STRIDE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       opcode,
  input  logic [DISP_W-1:0] disp,
  output logic              busy,
  output logic              done,
  output logic              unsupported,
  output logic [IDX_W-1:0]  rf_dsel,
  output logic [IDX_W-1:0]  rf_asel,
  input  logic [DATA_W-1:0] rf_dval,
  input  logic [ADDR_W-1:0] rf_aval,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_widx,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack
);
  localparam int NBYTES    = DATA_W / 8;
  localparam int CNT_W     = $clog2(NBYTES);
  localparam int LONG_LAST = NBYTES - 1;
  localparam int WORD_LAST = NBYTES / 2 - 1;

  seq_state_t        st_q, st_n;
  op_fields_t        fld_q, fld_dec;
  logic              hit;
  logic [DISP_W-1:0] disp_q;
  logic [DATA_W-1:0] data_q, data_n;
  logic              data_en;
  logic              unsup_n, unsup_q;
  logic              latch_en, load_en, step_en, last;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_init;
  logic [7:0]        sel_byte;
  logic [DATA_W-1:0] merged;
  logic              beat;

  altbyte_decode u_dec (
    .op_i  (opcode),
    .hit_o (hit),
    .fld_o (fld_dec)
  );

  assign cnt_init = fld_q.is_long ? CNT_W'(LONG_LAST) : CNT_W'(WORD_LAST);

  altbyte_step #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .CNT_W  (CNT_W),
    .STRIDE (STRIDE)
  ) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .step_en    (step_en),
    .base_i     (rf_aval),
    .disp_i     (disp_q),
    .cnt_init_i (cnt_init),
    .addr_o     (mem_addr),
    .cnt_o      (cnt),
    .last_o     (last)
  );

  altbyte_lane #(
    .NBYTES (NBYTES),
    .CNT_W  (CNT_W)
  ) u_lane (
    .word_i (data_q),
    .idx_i  (cnt),
    .byte_i (mem_rdata),
    .byte_o (sel_byte),
    .word_o (merged)
  );

  assign beat = (st_q == ST_MOVE) && mem_ack;

  always_comb begin
    st_n     = st_q;
    unsup_n  = 1'b0;
    latch_en = 1'b0;
    load_en  = 1'b0;
    step_en  = 1'b0;
    data_en  = 1'b0;
    data_n   = data_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (hit) begin
            latch_en = 1'b1;
            st_n     = ST_FETCH;
          end else begin
            unsup_n = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        load_en = 1'b1;
        data_en = 1'b1;
        data_n  = rf_dval;
        st_n    = ST_MOVE;
      end
      ST_MOVE: begin
        if (mem_ack) begin
          if (!fld_q.to_mem) begin
            data_en = 1'b1;
            data_n  = merged;
          end
          if (last) st_n = fld_q.to_mem ? ST_FIN : ST_WB;
          else      step_en = 1'b1;
        end
      end
      ST_WB:   st_n = ST_FIN;
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      unsup_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      unsup_q <= unsup_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= '0;
      disp_q <= '0;
    end else if (latch_en) begin
      fld_q  <= fld_dec;
      disp_q <= disp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_n;
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = (st_q == ST_FIN);
  assign unsupported = unsup_q;
  assign rf_dsel     = fld_q.dsel;
  assign rf_asel     = fld_q.asel;
  assign rf_we       = (st_q == ST_WB);
  assign rf_widx     = fld_q.dsel;
  assign rf_wdata    = data_q;
  assign mem_req     = (st_q == ST_MOVE);
  assign mem_we      = fld_q.to_mem;
  assign mem_wdata   = sel_byte;

  // R8: bus fields held until acknowledged
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R7: next access two bytes higher
  a_r7_stride: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !last |=> mem_req && (mem_addr == $past(mem_addr) + ADDR_W'(STRIDE)));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: write-back is followed by completion
  a_r9_wb_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> done && !rf_we);

  // R1: rejection leaves the block idle
  a_r1_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> !busy && !mem_req);

  // R5: store never writes the register file
  a_r5_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    beat && last && mem_we |=> done && !rf_we);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, rf_we, done}));
endmodule

// File: tb/tb_altbyte_xfer.sv
module tb_altbyte_xfer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] opcode;
  logic [15:0] disp;
  logic        busy, done, unsupported;
  logic [2:0]  rf_dsel, rf_asel, rf_widx;
  logic [31:0] rf_dval, rf_aval, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [31:0] dregs [8];
  logic [31:0] aregs [8];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign rf_dval = dregs[rf_dsel];
  assign rf_aval = aregs[rf_asel];

  altbyte_xfer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .disp(disp),
    .busy(busy), .done(done), .unsupported(unsupported),
    .rf_dsel(rf_dsel), .rf_asel(rf_asel), .rf_dval(rf_dval), .rf_aval(rf_aval),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic reject_op(input logic [15:0] op);
    @(negedge clk);
    start = 1'b1; opcode = op; disp = 16'h0042;
    @(negedge clk);
    chk("R1 unsupported pulse", {31'd0, unsupported}, 32'd1);
    chk("R1 busy low", {30'd0, busy, mem_req}, 32'd0);
    start = 1'b0;
    @(negedge clk);
    chk("R1 pulse ends", {29'd0, unsupported, busy, mem_req}, 32'd0);
  endtask

  task automatic run_op(input logic [2:0] dr, input logic [2:0] ar, input bit lng,
                        input bit tomem, input logic [15:0] dsp, input int lat, input bit poke);
    logic [15:0] op;
    logic [31:0] base, dval, expv, s_addr;
    logic [7:0]  s_wd;
    logic        s_we;
    int nb, k, wait_left, cyc, ack_cyc, we_cyc;
    bit got_done, saw_we;
    op    = 16'h0108 | (16'(dr) << 9) | 16'(ar) | (16'(lng) << 6) | (16'(tomem) << 7);
    base  = aregs[ar] + {{16{dsp[15]}}, dsp};
    dval  = dregs[dr];
    nb    = lng ? 4 : 2;
    if (lng)
      expv = {mem_byte(base), mem_byte(base + 32'd2), mem_byte(base + 32'd4), mem_byte(base + 32'd6)};
    else
      expv = {dval[31:16], mem_byte(base), mem_byte(base + 32'd2)};
    k = 0; wait_left = -1; cyc = 0; ack_cyc = -10; we_cyc = -10;
    got_done = 1'b0; saw_we = 1'b0;
    s_addr = '0; s_wd = '0; s_we = 1'b0;
    @(negedge clk);
    start = 1'b1; opcode = op; disp = dsp;
    while (!got_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        start  = poke;
        opcode = 16'h0188 ^ 16'(ar);
        disp   = 16'h1234;
      end
      if (cyc == 2) start = 1'b0;
      if (cyc == 1) chk("R2 register indices", {26'd0, rf_dsel, rf_asel}, {26'd0, dr, ar});
      if (mem_ack) begin
        mem_ack = 1'b0;
        wait_left = -1;
      end
      if (mem_req) begin
        if (k >= nb) begin
          chk("R4 extra access", 32'(k), 32'(nb));
          k++;
        end else if (wait_left == -1) begin
          chk(k == 0 ? "R3 start address" : "R7 stride address", mem_addr, base + 32'(2 * k));
          chk("R5 direction", {31'd0, mem_we}, {31'd0, tomem});
          if (tomem)
            chk("R6 store byte order", {24'd0, mem_wdata},
                {24'd0, lng ? dval[31 - 8*k -: 8] : dval[15 - 8*k -: 8]});
          s_addr = mem_addr; s_wd = mem_wdata; s_we = mem_we;
          wait_left = lat + (k % 2);
        end else begin
          chk("R8 hold", {mem_addr ^ s_addr} | {23'd0, mem_we ^ s_we, mem_wdata ^ s_wd}, 32'd0);
        end
        if (wait_left == 0 && k < nb) begin
          mem_ack = 1'b1;
          mem_rdata = mem_byte(mem_addr);
          k++;
          ack_cyc = cyc;
          wait_left = -2;
        end else if (wait_left > 0) begin
          wait_left--;
        end
      end
      if (rf_we) begin
        saw_we = 1'b1;
        we_cyc = cyc;
        chk("R9 load only write-back", {31'd0, tomem}, 32'd0);
        chk("R9 write index", {29'd0, rf_widx}, {29'd0, dr});
        chk("R9 write value", rf_wdata, expv);
        chk("R9 write-back timing", 32'(cyc), 32'(ack_cyc + 1));
        dregs[dr] = expv;
      end
      if (done) begin
        got_done = 1'b1;
        chk("R10 done timing", 32'(cyc), tomem ? 32'(ack_cyc + 1) : 32'(we_cyc + 1));
      end
    end
    chk("R10 done seen", {31'd0, got_done}, 32'd1);
    chk("R4 byte count", 32'(k), 32'(nb));
    chk("R9 write-back presence", {31'd0, saw_we}, {31'd0, !tomem});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 idle after completion", {29'd0, busy, mem_req, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = '0; disp = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 8; i++) begin
      dregs[i] = 32'h11223344 * (i + 1) ^ 32'hA5C3_0F96;
      aregs[i] = (i == 7) ? 32'hFFFF_FFF9 : 32'h0001_0000 * i + 32'h0000_0101 * (i + 3);
    end
    repeat (3) @(negedge clk);
    chk("R10 reset state", {26'd0, busy, done, unsupported, rf_we, mem_req, 1'b0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {29'd0, busy, done, unsupported}, 32'd0);

    for (int b = 0; b < 16; b++)
      if (16'hF138 & (16'd1 << b)) reject_op(16'h0108 ^ (16'd1 << b));
    for (int i = 0; i < 300; i++) begin
      logic [15:0] op;
      op = 16'(i * 16'h9E37 + i * 3);
      if ((op & 16'hF138) != 16'h0108) reject_op(op);
    end

    for (int dr = 0; dr < 8; dr++)
      for (int ar = 0; ar < 8; ar++)
        for (int md = 0; md < 4; md++) begin
          logic [15:0] dsp;
          case ((dr + ar + md) % 6)
            0: dsp = 16'h0000;
            1: dsp = 16'h8000;
            2: dsp = 16'hFFFF;
            3: dsp = 16'h7FFF;
            4: dsp = 16'(dr * 16'h1357 + ar * 16'h0111);
            default: dsp = 16'h0006;
          endcase
          run_op(3'(dr), 3'(ar), md[1], md[0], dsp, (dr + ar + md) % 3, dr == ar);
        end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule